// File: doc/BRIEF.md
# Transparent cyclic FIFO transmitter

This block is a raw serial transmit channel. A host loads up to 32 bytes into a small transmit store through a byte write port. It then writes a command byte to start sending. The bytes go out on one data line, one bit per rising clock edge, least significant bit first. The block adds no flags, no checksum and no inserted bits.

A one-shot command sends the stored bytes once and then raises an end-of-transmission status bit. A repeat command replays the same stored bytes without end, wrapping from the last byte back to the first, until a reset command stops the channel and empties the store. The data line rests at one whenever nothing is being sent. The clock input is the bit clock, and all host accesses are synchronous to it.

Top module: `cyc_tx_top`

## Requirements
- R1: After `rst_n` is asserted, `txd` is 1, `status` is 0x00, `irq` is 0 and the store is empty.
- R2: A command with bit 3 set (0x08), bit 0 clear and no repeat selection starts a single pass over N stored bytes. Bit k of byte j appears on `txd` in cycle 8j+k+1 after the command edge. `txd` returns to 1 after 8N cycles.
- R3: The edge that ends the last bit of a one-shot pass sets `status` bit 6 (0x40) and `irq`. The flag stays set until a `stat_ack` pulse clears it. If a set and an acknowledge fall on the same edge, the set wins.
- R4: Command 0x2A (bits 5, 3 and 1) starts cyclic sending. After the last stored byte, the first byte follows at once, and this repeats for every pass.
- R5: With `dma_mode` high, bits 5 and 3 alone (0x28) also start cyclic sending. With `dma_mode` low, 0x28 starts a one-shot pass.
- R6: A command with bit 0 set (0x01) stops any sending, empties the store, and makes `txd` 1 from the next cycle. It overrides every other bit in the same command byte, and a byte written in the same cycle is dropped.
- R7: While idle, `txd` is 1. A transmit command given when the store is empty is ignored, and `txd` stays 1.
- R8: A byte write is dropped while sending is in progress, when 32 bytes are already stored, or in the cycle in which a start command is accepted. While sending, any command without bit 0 has no effect.
- R9: Cyclic sending never sets the end flag and keeps the stored bytes. A completed one-shot pass leaves the store empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one bit leaves per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe for the store |
| wr_data | input | 8 | Byte to store |
| cmd_en | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte (bit 0 reset, bit 1 message end, bit 3 transmit, bit 5 repeat) |
| dma_mode | input | 1 | Lets repeat plus transmit start cyclic sending without the message-end bit |
| stat_ack | input | 1 | Clears the end-of-transmission flag |
| status | output | 8 | Status byte; bit 6 is the end-of-transmission flag, other bits read 0 |
| irq | output | 1 | Interrupt, high while the end flag is set |
| txd | output | 1 | Serial data out, idle high |

## Verification
Each host write, command or acknowledge is registered on one edge, so its effect is visible in the following cycle. For a start command, the first data bit is on `txd` in the cycle that follows the command edge. The end flag appears in the cycle after the eighth bit of the last byte. The bench applies its inputs 2 time units after a rising edge and updates its queue-based model on the same rising edges as the design. It compares `txd`, `irq` and `status` at every falling edge, so every check lands in the exact cycle where the result is due.

// File: rtl/cyc_tx_pkg.sv
package cyc_tx_pkg;
  localparam int CMD_RST = 0;
  localparam int CMD_END = 1;
  localparam int CMD_GO  = 3;
  localparam int CMD_REP = 5;
  localparam int ST_DONE = 6;

  typedef enum logic [1:0] {MD_IDLE = 2'd0, MD_ONCE = 2'd1, MD_LOOP = 2'd2} tx_mode_e;

  // Pick the sending mode from a start command.
  function automatic tx_mode_e pick_mode(input logic [7:0] c, input logic dma);
    return (c[CMD_REP] && (c[CMD_END] || dma)) ? MD_LOOP : MD_ONCE;
  endfunction

  // True when the pointer addresses the final stored byte.
  function automatic logic at_last(input int unsigned ptr, input int unsigned cnt);
    return (ptr + 1) == cnt;
  endfunction
endpackage

// File: rtl/cyc_tx_store.sv
module cyc_tx_store #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          flush,
  input  logic [PW-1:0] rd_ptr,
  output logic [W-1:0]  rd_byte,
  output logic [CW-1:0] count
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (push) mem[count[PW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (flush) count <= '0;
    else if (push)  count <= count + CW'(1);
  end

  assign rd_byte = mem[rd_ptr];
endmodule

// File: rtl/cyc_tx_seq.sv
module cyc_tx_seq
  import cyc_tx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  tx_mode_e      start_mode,
  input  logic          halt,
  input  logic [CW-1:0] count,
  output logic [PW-1:0] rd_ptr,
  output logic [2:0]    bit_idx,
  output logic          busy,
  output logic          pass_end,
  output logic          wrap
);
  tx_mode_e mode;
  logic     byte_done, last_byte;

  assign busy      = (mode != MD_IDLE);
  assign byte_done = busy && (bit_idx == 3'd7);
  assign last_byte = at_last(int'(rd_ptr), int'(count));
  assign pass_end  = byte_done && last_byte && (mode == MD_ONCE) && !halt;
  assign wrap      = byte_done && last_byte && (mode == MD_LOOP) && !halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MD_IDLE;
      rd_ptr  <= '0;
      bit_idx <= '0;
    end else if (halt) begin
      mode    <= MD_IDLE;
      rd_ptr  <= '0;
      bit_idx <= '0;
    end else if (start) begin
      mode    <= start_mode;
      rd_ptr  <= '0;
      bit_idx <= '0;
    end else if (busy) begin
      bit_idx <= bit_idx + 3'd1;
      if (byte_done) begin
        if (pass_end) begin
          mode   <= MD_IDLE;
          rd_ptr <= '0;
        end else if (wrap) begin
          rd_ptr <= '0;
        end else begin
          rd_ptr <= rd_ptr + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cyc_tx_flag.sv
module cyc_tx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/cyc_tx_top.sv
module cyc_tx_top
  import cyc_tx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cmd_en,
  input  logic [7:0] cmd_data,
  input  logic       dma_mode,
  input  logic       stat_ack,
  output logic [7:0] status,
  output logic       irq,
  output logic       txd
);
  // Named internal events, also observed by the bound checker.
  logic          halt_cmd, start_ev, wr_accept, flush, busy, pass_end, wrap, done_flag;
  logic [CW-1:0] fifo_cnt;
  logic [PW-1:0] rd_ptr;
  logic [2:0]    bit_idx;
  logic [7:0]    rd_byte;

  assign halt_cmd  = cmd_en && cmd_data[CMD_RST];
  assign start_ev  = cmd_en && cmd_data[CMD_GO] && !halt_cmd && !busy && (fifo_cnt != '0);
  assign wr_accept = wr_en && !busy && !start_ev && !halt_cmd && (fifo_cnt < CW'(DEPTH));
  assign flush     = halt_cmd || pass_end;

  cyc_tx_store #(.DEPTH(DEPTH), .W(8)) u_store (
    .clk(clk), .rst_n(rst_n), .push(wr_accept), .din(wr_data),
    .flush(flush), .rd_ptr(rd_ptr), .rd_byte(rd_byte), .count(fifo_cnt)
  );

  cyc_tx_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_ev),
    .start_mode(pick_mode(cmd_data, dma_mode)), .halt(halt_cmd),
    .count(fifo_cnt), .rd_ptr(rd_ptr), .bit_idx(bit_idx),
    .busy(busy), .pass_end(pass_end), .wrap(wrap)
  );

  cyc_tx_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(pass_end), .clr(stat_ack), .flag(done_flag)
  );

  assign txd    = busy ? rd_byte[bit_idx] : 1'b1;
  assign irq    = done_flag;
  assign status = 8'(done_flag) << ST_DONE;
endmodule

// File: rtl/cyc_tx_chk.sv
module cyc_tx_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd,
  input logic          busy,
  input logic          pass_end,
  input logic          wrap,
  input logic          flush,
  input logic [7:0]    status,
  input logic [CW-1:0] fifo_cnt
);
  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_done_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> status[6]);
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fifo_cnt == '0) && txd);
  assert_loop_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !status[6]) |=> !status[6]);
  assert_busy_store_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !flush) |=> $stable(fifo_cnt));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));
endmodule

bind cyc_tx_top cyc_tx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .busy(busy), .pass_end(pass_end),
  .wrap(wrap), .flush(flush), .status(status), .fifo_cnt(fifo_cnt)
);

// File: tb/sim_cyc_tx_top.sv
module sim_cyc_tx_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, cmd_en = 1'b0, dma_mode = 1'b0, stat_ack = 1'b0;
  logic [7:0] wr_data = '0, cmd_data = '0;
  logic [7:0] status;
  logic       irq, txd;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit finished = 0;

  // Behavioural reference model.
  logic [7:0] mq[$];
  int m_mode = 0;   // 0 idle, 1 once, 2 loop
  int m_ptr = 0, m_bit = 0, m_sz = 0;
  bit m_flag = 0, m_fin = 0;

  cyc_tx_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_en(cmd_en), .cmd_data(cmd_data), .dma_mode(dma_mode),
    .stat_ack(stat_ack), .status(status), .irq(irq), .txd(txd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    m_sz  = mq.size();
    m_fin = 0;
    if (!rst_n) begin
      mq.delete(); m_mode = 0; m_ptr = 0; m_bit = 0; m_flag = 0;
    end else begin
      if (cmd_en && cmd_data[0]) begin
        mq.delete(); m_mode = 0; m_ptr = 0; m_bit = 0;
      end else if (m_mode != 0) begin
        if (m_bit == 7) begin
          m_bit = 0;
          if (m_ptr == m_sz - 1) begin
            m_ptr = 0;
            if (m_mode == 1) begin mq.delete(); m_mode = 0; m_fin = 1; end
          end else m_ptr++;
        end else m_bit++;
      end else if (cmd_en && cmd_data[3] && m_sz > 0) begin
        m_mode = (cmd_data[5] && (cmd_data[1] || dma_mode)) ? 2 : 1;
        m_ptr = 0; m_bit = 0;
      end else if (wr_en && m_sz < DEPTH) begin
        mq.push_back(wr_data);
      end
      if (m_fin) m_flag = 1;
      else if (stat_ack) m_flag = 0;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  logic exp_txd;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      exp_txd = (m_mode != 0) ? mq[m_ptr][m_bit] : 1'b1;
      check(txd === exp_txd, "txd", int'(txd), int'(exp_txd));
      check(irq === m_flag, "irq", int'(irq), int'(m_flag));
      check(status === (8'(m_flag) << 6), "status", int'(status), int'(8'(m_flag) << 6));
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask
  task automatic put(input logic [7:0] b);
    wr_en = 1; wr_data = b; step(1); wr_en = 0;
  endtask
  task automatic cmd(input logic [7:0] c);
    cmd_en = 1; cmd_data = c; step(1); cmd_en = 0;
  endtask
  task automatic ack();
    stat_ack = 1; step(1); stat_ack = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1; #1;
    // R1: reset state at the ports
    check(txd === 1'b1, "reset txd", int'(txd), 1);
    check(status === 8'h00, "reset status", int'(status), 0);
    check(irq === 1'b0, "reset irq", int'(irq), 0);
    step(2);

    // R7: empty store, transmit ignored
    tag = "R7"; cmd(8'h08); step(5);

    // R2 / R3: one-shot of three bytes, LSB first, flag afterwards
    tag = "R2"; put(8'hA5); put(8'h3C); put(8'h01);
    cmd(8'h08);
    // R8: writes and commands while sending are ignored
    tag = "R8"; put(8'hFF); cmd(8'h2A); step(3);
    tag = "R3"; step(25);
    // R9: store empty after one-shot, so a new transmit is ignored
    tag = "R9"; cmd(8'h08); step(3);
    tag = "R3"; stat_ack = 1; step(1); stat_ack = 0; step(2);

    // R4: cyclic replay of two bytes, never sets the flag (R9)
    tag = "R4"; put(8'h81); put(8'h6E); cmd(8'h2A); step(40);
    tag = "R8"; put(8'h55); cmd(8'h08); step(10);
    // R6: reset command stops replay and empties the store
    tag = "R6"; cmd(8'h01); step(4); cmd(8'h08); step(3);

    // R5: dma mode allows 0x28 for cyclic sending
    tag = "R5"; dma_mode = 1; put(8'hC3); cmd(8'h28); step(30); cmd(8'h01);
    dma_mode = 0; put(8'h96); cmd(8'h28); step(12); ack(); step(2);

    // R8: 34 writes, only 32 kept; start in same cycle as write drops it
    tag = "R8";
    for (int i = 0; i < 34; i++) put(8'(i * 7 + 3));
    wr_en = 1; wr_data = 8'hEE; cmd(8'h08); wr_en = 0;
    step(DEPTH * 8 + 4); ack();

    // R6: reset bit overrides start bits, same-cycle write dropped
    tag = "R6"; put(8'h5A);
    wr_en = 1; wr_data = 8'h11; cmd(8'h2B); wr_en = 0; step(4);
    cmd(8'h08); step(4);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule